// File: doc/BRIEF.md
# Self-Timed Programming and Status Sequencer

This block sits behind the serial command decoder of a small serial non-volatile memory. It keeps the write-enable latch and carries out the four programming commands: single-word write, single-word erase, fill-all and clear-all. The decoder hands over each complete instruction as a one-cycle strobe with an opcode, an address and a data word. The block keeps a programming command pending until chip select falls. At that edge it starts a self-timed cycle, but only if the latch is set and the supply is good. Otherwise it drops the command.

During the cycle the block drives an internal array write port. Each affected word is first erased to all ones and then, for commands that carry data, written with the data. The cycle ends after a fixed number of system clocks. A status flag is armed when the cycle starts. While chip select is high and the flag is armed, DO is driven: 0 means busy and 1 means ready. The flag is cleared when chip select and DI are high on a rising serial-clock edge.

The chip-select, serial-clock and DI pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are taken from the synchronised values.

Top module: `psq_top`

## Requirements
- R1: After reset the write-enable latch is cleared, DO is not driven (`do_oe`=0), no array write occurs, and a programming command issued before any enable command causes no array write.
- R2: A pending programming command (opcode 4, 5, 6 or 7) starts a cycle at the synchronised falling edge of chip select only if the enable latch is set and `supply_ok` is 1. Otherwise it is discarded, and a later chip-select fall does not start it.
- R3: Opcode 2 sets the enable latch and opcode 3 clears it. Opcodes 0 (none) and 1 (read) leave the latch unchanged.
- R4: Once started, a cycle stays busy for exactly `PROG_CYCLES` system clocks.
- R5: While synchronised chip select is high and the status flag is armed, `do_oe` is 1 and `do_out` is 0 during the cycle and 1 after it ends.
- R6: Array writes occur on consecutive clocks starting with the start cycle. Opcode 4 writes all ones to the address, then the data. Opcode 5 writes all ones to the address once. Opcode 6 writes all ones to every word in ascending order and then the data to every word in ascending order. Opcode 7 writes all ones to every word in ascending order.
- R7: A rising edge of the synchronised serial clock while the synchronised chip select and DI are both high clears the status flag, so `do_oe` goes to 0.
- R8: While busy, command strobes and chip-select falls have no effect: the enable latch is unchanged and no second cycle starts.
- R9: The cycle starts on the third rising system-clock edge after the raw chip-select pin falls. One edge is taken by each synchroniser flop and one by the edge detector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| cs_pin | input | 1 | Raw chip-select pin, asynchronous |
| sk_pin | input | 1 | Raw serial clock pin, asynchronous |
| di_pin | input | 1 | Raw serial data-in pin, asynchronous |
| supply_ok | input | 1 | Supply above lockout level |
| cmd_valid | input | 1 | One-cycle strobe: a decoded instruction is complete |
| cmd_op | input | 3 | Decoded opcode (0 none, 1 read, 2 enable, 3 disable, 4 write, 5 erase, 6 fill-all, 7 clear-all) |
| cmd_addr | input | ADDR_W | Decoded word address |
| cmd_data | input | DATA_W | Decoded data word |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| do_out | output | 1 | Status value for DO (1 ready, 0 busy) |
| do_oe | output | 1 | DO output enable (0 means tri-state) |

## Verification
The assertions assume that `cmd_valid` is pulsed only while chip select is high and never in the same cycle as a chip-select fall. They also assume that `PROG_CYCLES` is at least twice the word count, so that the erase and program sweeps fit inside the busy window. The stimulus raises chip select several clocks before each command strobe and lowers it only after the strobe. It uses a programming interval of 40 clocks for an 8-word array. The pins change on the falling system-clock edge, so each synchroniser sees a clean level.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WREN  = 3'd2,
        OP_WRDIS = 3'd3,
        OP_WRITE = 3'd4,
        OP_ERASE = 3'd5,
        OP_FILL  = 3'd6,
        OP_CLEAR = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ERASE,
        PH_PROG,
        PH_HOLD
    } phase_e;

    // Commands that start a self-timed cycle
    function automatic logic is_prog(op_e o);
        return (o == OP_WRITE) || (o == OP_ERASE) || (o == OP_FILL) || (o == OP_CLEAR);
    endfunction

    // Commands that carry a data word after the erase step
    function automatic logic has_data(op_e o);
        return (o == OP_WRITE) || (o == OP_FILL);
    endfunction

    // Commands that sweep the whole array
    function automatic logic is_bulk(op_e o);
        return (o == OP_FILL) || (o == OP_CLEAR);
    endfunction

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta;
        logic stable_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta     <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta     <= d_in[i];
                stable_q <= meta;
            end
        end
        assign q[i] = stable_q;
    end
endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
    import psq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              busy,
    input  logic              supply_ok,
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              wen,
    output logic              launch,
    output op_e               job_op,
    output logic [ADDR_W-1:0] job_addr,
    output logic [DATA_W-1:0] job_data
);
    op_e               pend_op;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            wen       <= 1'b0;
            pend_op   <= OP_NONE;
            pend_addr <= '0;
            pend_data <= '0;
        end else if (cs_fall) begin
            // a chip-select fall consumes or discards whatever was pending
            pend_op <= OP_NONE;
        end else if (cmd_valid && !busy) begin
            unique case (cmd_op)
                OP_WREN: begin
                    wen     <= 1'b1;
                    pend_op <= OP_NONE;
                end
                OP_WRDIS: begin
                    wen     <= 1'b0;
                    pend_op <= OP_NONE;
                end
                OP_WRITE, OP_ERASE, OP_FILL, OP_CLEAR: begin
                    pend_op   <= cmd_op;
                    pend_addr <= cmd_addr;
                    pend_data <= cmd_data;
                end
                default: pend_op <= OP_NONE;
            endcase
        end
    end

    assign launch   = cs_fall && !busy && is_prog(pend_op) && wen && supply_ok;
    assign job_op   = pend_op;
    assign job_addr = pend_addr;
    assign job_data = pend_data;
endmodule

// File: rtl/psq_engine.sv
module psq_engine
    import psq_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  op_e               job_op,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [DATA_W-1:0] job_data,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int TW    = $clog2(PROG_CYCLES + 1);
    localparam logic [TW-1:0]     T_LAST = TW'(PROG_CYCLES - 1);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(WORDS - 1);

    phase_e            phase;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] idx;
    logic [TW-1:0]     timer;
    logic              sweep_last;

    assign sweep_last = !is_bulk(op_q) || (idx == A_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            phase  <= PH_IDLE;
            op_q   <= OP_NONE;
            addr_q <= '0;
            data_q <= '0;
            idx    <= '0;
            timer  <= '0;
        end else if (launch) begin
            busy   <= 1'b1;
            phase  <= PH_ERASE;
            op_q   <= job_op;
            addr_q <= job_addr;
            data_q <= job_data;
            idx    <= '0;
            timer  <= '0;
        end else if (busy) begin
            unique case (phase)
                PH_ERASE: begin
                    if (sweep_last) begin
                        idx   <= '0;
                        phase <= has_data(op_q) ? PH_PROG : PH_HOLD;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_PROG: begin
                    if (sweep_last) phase <= PH_HOLD;
                    else            idx   <= idx + 1'b1;
                end
                default: ;
            endcase
            if (timer == T_LAST) begin
                busy  <= 1'b0;
                phase <= PH_IDLE;
            end else begin
                timer <= timer + 1'b1;
            end
        end
    end

    assign mem_we    = (phase == PH_ERASE) || (phase == PH_PROG);
    assign mem_addr  = is_bulk(op_q) ? idx : addr_q;
    assign mem_wdata = (phase == PH_ERASE) ? {DATA_W{1'b1}} : data_q;
endmodule

// File: rtl/psq_status.sv
module psq_status (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic busy,
    input  logic cs_s,
    input  logic di_s,
    input  logic sk_rise,
    output logic do_out,
    output logic do_oe
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)                           armed <= 1'b0;
        else if (launch)                   armed <= 1'b1;
        else if (cs_s && di_s && sk_rise)  armed <= 1'b0;
    end

    assign do_oe  = armed && cs_s;
    assign do_out = !busy;
endmodule

// File: rtl/psq_top.sv
module psq_top
    import psq_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_pin,
    input  logic              sk_pin,
    input  logic              di_pin,
    input  logic              supply_ok,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              do_out,
    output logic              do_oe
);
    localparam int NPIN = 3;

    logic [NPIN-1:0]   pin_s;
    logic              cs_s, sk_s, di_s;
    logic              cs_prev, sk_prev;
    logic              cs_fall, sk_rise;
    logic              wen, launch, busy;
    op_e               job_op;
    logic [ADDR_W-1:0] job_addr;
    logic [DATA_W-1:0] job_data;

    psq_sync #(.N(NPIN)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .d_in ({di_pin, sk_pin, cs_pin}),
        .q    (pin_s)
    );

    assign cs_s = pin_s[0];
    assign sk_s = pin_s[1];
    assign di_s = pin_s[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev <= 1'b0;
            sk_prev <= 1'b0;
        end else begin
            cs_prev <= cs_s;
            sk_prev <= sk_s;
        end
    end

    assign cs_fall = cs_prev && !cs_s;
    assign sk_rise = sk_s && !sk_prev;

    psq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .cs_fall   (cs_fall),
        .busy      (busy),
        .supply_ok (supply_ok),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_e'(cmd_op)),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .wen       (wen),
        .launch    (launch),
        .job_op    (job_op),
        .job_addr  (job_addr),
        .job_data  (job_data)
    );

    psq_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) eng_i (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .job_op    (job_op),
        .job_addr  (job_addr),
        .job_data  (job_data),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    psq_status stat_i (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .busy    (busy),
        .cs_s    (cs_s),
        .di_s    (di_s),
        .sk_rise (sk_rise),
        .do_out  (do_out),
        .do_oe   (do_oe)
    );
endmodule

// File: rtl/psq_chk.sv
module psq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              supply_ok,
    input logic              wen,
    input logic              busy,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);
    // R1
    reset_wen_off_chk: assert property (@(posedge clk) rst |=> !wen);

    // R2
    launch_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wen && supply_ok));

    // R6
    erase_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_we && mem_wdata == {DATA_W{1'b1}}));

    // R8
    write_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R8
    wen_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(wen));
endmodule

bind psq_top psq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .wen       (wen),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/psq_top_tb_top.sv
module psq_top_tb_top;
    localparam int AW    = 3;
    localparam int DW    = 16;
    localparam int PROG  = 40;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_pin = 1'b0, sk_pin = 1'b0, di_pin = 1'b0;
    logic          supply_ok = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          mem_we, do_out, do_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    int busy_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    psq_top #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst(rst), .cs_pin(cs_pin), .sk_pin(sk_pin), .di_pin(di_pin),
        .supply_ok(supply_ok), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .do_out(do_out), .do_oe(do_oe)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [2:0]         p1, p2, pp;     // pin history {di, sk, cs}
    bit               m_wen, m_busy, m_arm;
    int               m_pend, m_left;
    bit [AW-1:0]      m_pa;
    bit [DW-1:0]      m_pd;
    bit [AW+DW-1:0]   wq[$];

    always @(posedge clk) begin
        if (rst) begin
            p1 = 0; p2 = 0; pp = 0;
            m_wen = 0; m_busy = 0; m_arm = 0; m_pend = 0; m_left = 0;
            wq.delete();
        end else begin
            bit fall, skr, clr, go, was_busy;
            fall = pp[0] && !p2[0];
            skr  = p2[1] && !pp[1];
            clr  = p2[0] && p2[2] && skr;
            go   = fall && !m_busy && m_pend >= 4 && m_wen && supply_ok;
            was_busy = m_busy;
            if (m_busy) begin
                if (wq.size() > 0) void'(wq.pop_front());
                m_left--;
                if (m_left == 0) m_busy = 0;
            end
            if (go) begin
                if (m_pend == 6 || m_pend == 7)
                    for (int a = 0; a < WORDS; a++) wq.push_back({AW'(a), {DW{1'b1}}});
                else
                    wq.push_back({m_pa, {DW{1'b1}}});
                if (m_pend == 4) wq.push_back({m_pa, m_pd});
                if (m_pend == 6)
                    for (int a = 0; a < WORDS; a++) wq.push_back({AW'(a), m_pd});
                m_busy = 1; m_left = PROG; m_arm = 1;
            end else if (clr) m_arm = 0;
            if (fall) m_pend = 0;
            else if (cmd_valid && !was_busy) begin
                case (cmd_op)
                    3'd2: begin m_wen = 1; m_pend = 0; end
                    3'd3: begin m_wen = 0; m_pend = 0; end
                    3'd4, 3'd5, 3'd6, 3'd7: begin m_pend = cmd_op; m_pa = cmd_addr; m_pd = cmd_data; end
                    default: m_pend = 0;
                endcase
            end
            pp = p2; p2 = p1; p1 = {di_pin, sk_pin, cs_pin};
        end
    end

    // per-clock comparison, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R5 do_oe", do_oe, m_arm && p2[0]);
            chk("R4 do_out", do_out, !m_busy);
            chk("R6 mem_we", mem_we, wq.size() > 0);
            if (wq.size() > 0) begin
                chk("R6 mem_addr", mem_addr, wq[0][AW+DW-1:DW]);
                chk("R6 mem_wdata", mem_wdata, wq[0][DW-1:0]);
            end
            if (mem_we) wr_cnt++;
            if (!do_out) busy_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
        tick(1);
        cmd_valid = 1'b0;
        tick(1);
    endtask

    // CS high, command, CS low, CS high again
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs_pin = 1'b1; tick(3);
        send(op, a, d);
        cs_pin = 1'b0; tick(5);
        cs_pin = 1'b1; tick(4);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (do_out) break;
            tick(1);
        end
        tick(2);
    endtask

    task automatic clear_status();
        di_pin = 1'b1; tick(3);
        sk_pin = 1'b1; tick(4);
        sk_pin = 1'b0; di_pin = 1'b0; tick(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 do_oe after reset", do_oe, 0);
        chk("R1 mem_we after reset", mem_we, 0);

        // R1 programming before enable is ignored
        wr_cnt = 0;
        issue(3'd4, 3'd1, 16'h1234);
        wait_done();
        chk("R1 no write while disabled", wr_cnt, 0);
        chk("R1 no status while disabled", do_oe, 0);

        // enable, then a WRITE; R9 latency, R5 status, R4 length, R6 writes
        issue(3'd2, 0, 0);
        cs_pin = 1'b1; tick(3);
        send(3'd4, 3'd3, 16'hA5A5);
        wr_cnt = 0; busy_cnt = 0;
        cs_pin = 1'b0;
        tick(2);
        chk("R9 idle two clocks after cs fall", do_out, 1);
        tick(1);
        chk("R9 busy three clocks after cs fall", do_out, 0);
        cs_pin = 1'b1; tick(4);
        chk("R5 status driven while busy", do_oe, 1);
        chk("R5 busy reads 0", do_out, 0);
        wait_done();
        chk("R5 ready reads 1", do_out, 1);
        chk("R5 status still driven", do_oe, 1);
        chk("R4 busy length", busy_cnt, PROG);
        chk("R6 write count single write", wr_cnt, 2);

        // R7 status clear
        clear_status();
        chk("R7 status cleared", do_oe, 0);

        // R2 supply low drops command, later fall does not revive it
        supply_ok = 1'b0; wr_cnt = 0;
        issue(3'd5, 3'd2, 0);
        supply_ok = 1'b1;
        cs_pin = 1'b0; tick(5); cs_pin = 1'b1; tick(4);
        wait_done();
        chk("R2 supply low drops command", wr_cnt, 0);
        chk("R2 no status after drop", do_oe, 0);

        // R6 erase, fill, clear
        wr_cnt = 0; issue(3'd5, 3'd6, 0); wait_done();
        chk("R6 erase count", wr_cnt, 1);
        wr_cnt = 0; issue(3'd6, 0, 16'h3C3C); wait_done();
        chk("R6 fill count", wr_cnt, 2 * WORDS);
        wr_cnt = 0; issue(3'd7, 0, 0); wait_done();
        chk("R6 clear count", wr_cnt, WORDS);
        clear_status();

        // R8 disable and a second write during busy are ignored
        wr_cnt = 0;
        issue(3'd4, 3'd4, 16'h00FF);
        send(3'd3, 0, 0);
        send(3'd4, 3'd5, 16'h0F0F);
        cs_pin = 1'b0; tick(5); cs_pin = 1'b1; tick(4);
        wait_done();
        chk("R8 no second cycle while busy", wr_cnt, 2);
        wr_cnt = 0;
        issue(3'd4, 3'd5, 16'h1111); wait_done();
        chk("R8 enable kept through busy disable", wr_cnt, 2);

        // R3 read leaves latch; disable blocks
        wr_cnt = 0;
        issue(3'd3, 0, 0);
        issue(3'd1, 0, 0);
        issue(3'd4, 3'd0, 16'h2222); wait_done();
        chk("R3 disabled latch blocks write", wr_cnt, 0);
        issue(3'd2, 0, 0);
        issue(3'd1, 0, 0);
        issue(3'd0, 0, 0);
        wr_cnt = 0;
        issue(3'd4, 3'd7, 16'h4444); wait_done();
        chk("R3 read keeps latch set", wr_cnt, 2);

        tick(5);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule